// File: doc/BRIEF.md
# Reed-Solomon Parity Encoder (544,514) over 10-bit Symbols

This block fills in the parity of a systematic Reed-Solomon code with 544 symbols per codeword and 514 message symbols. Each symbol is 10 bits wide, so a codeword carries 5440 bits: 5140 message bits and 30 parity symbols. The upstream formatter hands over whole codewords, one symbol per cycle. The last 30 slots of each codeword are placeholders that should hold zeros. The encoder passes the message symbols through unchanged and feeds them into a 30-stage parity shift register. It then writes the computed parity into the placeholder slots, so no symbols are appended after the message.

The stream uses a valid/ready handshake with start and end markers. The path is combinational from input to output: the output valid follows the input valid, the input ready follows the output ready, and the markers pass straight through. A symbol is transferred in any cycle where valid and ready are both high. A stall or a gap in valid freezes all state. One instance serves one logical slice. Two slices can run as independent channels, or a lane distributor after them can combine them into a faster channel.

Top module: `rs_parity_encoder`

## Requirements
- R1: At codeword positions 0 to 513, `out_data` equals `in_data` in the same cycle.
- R2: Positions 514 to 543 carry parity, highest degree first, so that every emitted codeword has zero syndromes. Arithmetic is in GF(2^10) with x^10+x^3+1. The symbol at position p is the coefficient of x^(543-p). The roots are alpha^i for i = 0..29, where alpha is x.
- R3: Input data at positions 514 to 543 has no effect on the output. Nonzero placeholders give the same parity as zero placeholders.
- R4: A transfer with `in_sof` high restarts at position 0 with cleared parity. This holds even in the middle of a codeword, so each codeword is independent of what came before.
- R5: `in_ready` equals `out_ready`. Cycles with `out_ready` low change no state, so a stalled codeword yields the same parity as an unstalled one.
- R6: `out_valid` equals `in_valid`. Cycles with `in_valid` low change no state.
- R7: While `rst_n` is low at a clock edge, the position is cleared to 0 and the parity is cleared. The first codeword after reset encodes correctly even without `in_sof`.
- R8: `out_sof` and `out_eof` equal `in_sof` and `in_eof` in the same cycle.
- R9: An all-zero message gives all-zero parity. A message whose only nonzero symbol is 1 at position 513 gives parity equal to the generator coefficients g29 down to g0. Here g(x) is the product of (x + alpha^i) for i = 0..29.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input symbol valid |
| in_ready | output | 1 | Input symbol accepted when high together with valid |
| in_data | input | SYM_W | Input symbol |
| in_sof | input | 1 | First symbol of a codeword |
| in_eof | input | 1 | Last symbol of a codeword |
| out_valid | output | 1 | Output symbol valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | SYM_W | Message symbol or parity symbol |
| out_sof | output | 1 | First symbol marker, passed through |
| out_eof | output | 1 | Last symbol marker, passed through |

## Verification
The bench builds the block with its default parameters: 10-bit symbols, 544-symbol codewords, 514 message symbols and the x^10+x^3+1 field. At these values the full 30-root syndrome test runs on every codeword. The single-symbol message at position 513 exposes each generator coefficient directly in the output. The bench also replays one message under stalls, valid gaps, nonzero placeholders, an aborted codeword and a mid-codeword reset, and compares the parity bit for bit.

// File: rtl/rs_enc_pkg.sv
// Package: Galois-field helpers for the parity encoder.
// Assumes field polynomials are given with the x^W term included
// and that the parity count stays below 64.
package rs_enc_pkg;

    // Multiply two field elements of width w modulo poly.
    function automatic int gf_mul(int a, int b, int w, int poly);
        int r;
        int x;
        r = 0;
        x = a;
        for (int k = 0; k < w; k++) begin
            if (((b >> k) & 1) != 0) r = r ^ x;
            x = x << 1;
            if (((x >> w) & 1) != 0) x = x ^ poly;
        end
        return r;
    endfunction

    // Coefficient idx of prod_{i<npar} (x + alpha^i), alpha = x.
    function automatic int gen_coef(int idx, int npar, int w, int poly);
        int g [0:63];
        int root;
        for (int j = 0; j < 64; j++) g[j] = 0;
        g[0] = 1;
        root = 1;
        for (int i = 0; i < npar; i++) begin
            for (int j = i + 1; j >= 1; j--) g[j] = g[j-1] ^ gf_mul(g[j], root, w, poly);
            g[0] = gf_mul(g[0], root, w, poly);
            root = gf_mul(root, 2, w, poly);
        end
        return g[idx];
    endfunction

endpackage

// File: rtl/rs_gf_cmul.sv
// Module: multiply a field element by a constant fixed at elaboration.
// Builds one column per input bit (COEF * alpha^i) and XORs the
// columns selected by the input bits. Purely combinational.
module rs_gf_cmul #(
    parameter int W    = 10,
    parameter int POLY = 'h409,
    parameter int COEF = 1
) (
    input  logic [W-1:0] a,
    output logic [W-1:0] p
);
    // XOR together the constant columns picked by the set bits of a.
    always_comb begin
        p = '0;
        for (int i = 0; i < W; i++) begin
            if (a[i]) p = p ^ W'(rs_enc_pkg::gf_mul(COEF, 1 << i, W, POLY));
        end
    end
endmodule

// File: rtl/rs_pos_tracker.sv
// Module: tracks the symbol position inside the current codeword.
// A transfer flagged as start forces position 0. The position wraps
// after N-1. It assumes the marker, when used, comes on the first symbol.
module rs_pos_tracker #(
    parameter int N = 544,
    parameter int K = 514,
    localparam int PW = $clog2(N)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic start,
    output logic in_parity,
    output logic at_last
);
    logic [PW-1:0] cnt_q;
    logic [PW-1:0] pos_eff;

    // Effective position of the symbol presented this cycle.
    always_comb begin
        pos_eff   = start ? '0 : cnt_q;
        in_parity = (pos_eff >= PW'(K));
        at_last   = (pos_eff == PW'(N - 1));
    end

    // Advance the position on each transfer, wrapping at codeword end.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (adv)    cnt_q <= at_last ? '0 : pos_eff + PW'(1);
    end

    assert_pos_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < PW'(N));

    assert_pos_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && at_last) |=> (cnt_q == '0));
endmodule

// File: rtl/rs_parity_lfsr.sv
// Module: 30-stage (NPAR) parity shift register for the systematic encoder.
// In message phase it divides by the generator polynomial. In parity phase
// it shifts toward the top stage and fills zeros from below.
// A start marker makes the update begin from a cleared register.
module rs_parity_lfsr #(
    parameter int W    = 10,
    parameter int NPAR = 30,
    parameter int POLY = 'h409
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    input  logic         start,
    input  logic         shift_out,
    input  logic [W-1:0] din,
    output logic [W-1:0] top_sym
);
    logic [NPAR-1:0][W-1:0] par_q;
    logic [NPAR-1:0][W-1:0] base;
    logic [NPAR-1:0][W-1:0] nxt;
    logic [W-1:0]           fb;

    // Select the starting state and form the feedback symbol.
    always_comb begin
        base    = start ? '0 : par_q;
        fb      = din ^ base[NPAR-1];
        top_sym = base[NPAR-1];
    end

    // One stage per parity symbol with its generator coefficient.
    for (genvar j = 0; j < NPAR; j++) begin : g_stage
        localparam int GC = rs_enc_pkg::gen_coef(j, NPAR, W, POLY);
        logic [W-1:0] prod;
        rs_gf_cmul #(.W(W), .POLY(POLY), .COEF(GC)) u_mul (.a(fb), .p(prod));
        if (j == 0) begin : g_low
            assign nxt[j] = shift_out ? '0 : prod;
        end else begin : g_mid
            assign nxt[j] = shift_out ? base[j-1] : (base[j-1] ^ prod);
        end
    end

    // Load the next state on each transfer; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)   par_q <= '0;
        else if (adv) par_q <= nxt;
    end

    assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(par_q));
endmodule

// File: rtl/rs_parity_encoder.sv
// Module: top of the systematic RS(544,514) parity encoder, one symbol per cycle.
// Message symbols pass through. The zeroed parity slots are replaced by the
// register contents, highest degree first. Handshake and markers pass through
// without buffering. It assumes each codeword is N symbols long.
module rs_parity_encoder #(
    parameter int SYM_W     = 10,
    parameter int N_SYM     = 544,
    parameter int K_SYM     = 514,
    parameter int PRIM_POLY = 'h409,
    localparam int NPAR     = N_SYM - K_SYM
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [SYM_W-1:0] in_data,
    input  logic             in_sof,
    input  logic             in_eof,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [SYM_W-1:0] out_data,
    output logic             out_sof,
    output logic             out_eof
);
    logic             xfer;
    logic             in_parity;
    logic             at_last;
    logic [SYM_W-1:0] par_sym;

    // Handshake and marker pass-through; transfer qualifier.
    always_comb begin
        xfer      = in_valid && out_ready;
        in_ready  = out_ready;
        out_valid = in_valid;
        out_sof   = in_sof;
        out_eof   = in_eof;
    end

    rs_pos_tracker #(.N(N_SYM), .K(K_SYM)) u_pos (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (xfer),
        .start     (in_sof),
        .in_parity (in_parity),
        .at_last   (at_last)
    );

    rs_parity_lfsr #(.W(SYM_W), .NPAR(NPAR), .POLY(PRIM_POLY)) u_lfsr (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (xfer),
        .start     (in_sof),
        .shift_out (in_parity),
        .din       (in_data),
        .top_sym   (par_sym)
    );

    // Choose message pass-through or parity symbol for the output.
    always_comb out_data = in_parity ? par_sym : in_data;

    assert_msg_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_parity) |-> (out_data == in_data));

    assert_drained_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && at_last) |=> (u_lfsr.par_q == '0));
endmodule

// File: tb/sim_rs_parity_encoder.sv
module sim_rs_parity_encoder;
    localparam int W  = 10;
    localparam int N  = 544;
    localparam int K  = 514;
    localparam int NP = N - K;
    localparam int PP = 'h409;

    logic clk = 1'b0;
    logic rst_n, in_valid, in_ready, in_sof, in_eof;
    logic out_valid, out_ready, out_sof, out_eof;
    logic [W-1:0] in_data, out_data;

    always #10 clk = ~clk;

    rs_parity_encoder u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sof(out_sof), .out_eof(out_eof)
    );

    int n_checks = 0;
    int n_fail   = 0;
    logic [W-1:0] cap [N];
    logic         sof_cap [N];
    logic         eof_cap [N];
    logic [W-1:0] ref_par [NP];
    int           gpoly [NP+1];

    function automatic int gmul(int a, int b);
        int r = 0;
        int x = a;
        for (int k = 0; k < W; k++) begin
            if (b[k]) r ^= x;
            x <<= 1;
            if (x[W]) x ^= PP;
        end
        return r;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int sym_of(int seed, int j, int kind);
        if (kind == 1) return 0;
        if (kind == 2) return (j == K - 1) ? 1 : 0;
        return (seed * 37 + j * j * 13 + j * 5 + 1) & 'h3ff;
    endfunction

    function automatic int syn_bad();
        int bad = 0;
        int a = 1;
        for (int i = 0; i < NP; i++) begin
            int s = 0;
            for (int j = 0; j < N; j++) s = gmul(s, a) ^ int'(cap[j]);
            if (s != 0) bad++;
            a = gmul(a, 2);
        end
        return bad;
    endfunction

    function automatic int par_diff();
        int d = 0;
        for (int t = 0; t < NP; t++) if (cap[K+t] !== ref_par[t]) d++;
        return d;
    endfunction

    // Send one full codeword; checks pass-through, markers, handshake, syndromes.
    task automatic run_cw(int seed, bit stall, bit gap, bit junk, bit use_sof, int kind);
        int j = 0, cyc = 0, mism = 0, hs = 0, mk = 0;
        while (j < N) begin
            @(negedge clk);
            out_ready = !(stall && (cyc % 3 == 1));
            in_valid  = !(gap && (cyc % 4 == 2));
            in_data   = (j >= K) ? (junk ? W'(j * 7 + 3) : '0) : W'(sym_of(seed, j, kind));
            if (!in_valid) in_data = 10'h2aa;
            in_sof    = use_sof && (j == 0);
            in_eof    = (j == N - 1);
            #2;
            if (in_ready !== out_ready || out_valid !== in_valid) hs++;
            if (in_valid && out_ready) begin
                cap[j] = out_data; sof_cap[j] = out_sof; eof_cap[j] = out_eof;
                if (j < K && out_data !== in_data) mism++;
                j++;
            end
            cyc++;
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        for (int p = 0; p < N; p++)
            if (sof_cap[p] !== (use_sof && p == 0) || eof_cap[p] !== (p == N - 1)) mk++;
        chk(mism == 0, "R1", "message symbols altered", mism, 0);
        chk(syn_bad() == 0, "R2", "nonzero syndromes", syn_bad(), 0);
        chk(mk == 0, "R8", "marker mismatches", mk, 0);
        chk(hs == 0, "R5", "handshake mismatches", hs, 0);
    endtask

    task automatic send_partial(int count, bit use_sof, int seed);
        for (int j = 0; j < count; j++) begin
            @(negedge clk);
            out_ready = 1'b1; in_valid = 1'b1;
            in_data = W'(sym_of(seed, j, 0)); in_sof = use_sof && (j == 0); in_eof = 1'b0;
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        do_reset();
        #2;
        chk(out_valid === 1'b0, "R7", "out_valid after reset", int'(out_valid), 0);
        run_cw(11, 0, 0, 0, 0, 0);
        chk(syn_bad() == 0, "R7", "first codeword without sof", syn_bad(), 0);
    endtask

    task automatic t_reference();
        run_cw(5, 0, 0, 0, 1, 0);
        for (int t = 0; t < NP; t++) ref_par[t] = cap[K+t];
    endtask

    task automatic t_stall();
        run_cw(5, 1, 0, 0, 1, 0);
        chk(par_diff() == 0, "R5", "parity differs under stalls", par_diff(), 0);
    endtask

    task automatic t_gaps();
        run_cw(5, 0, 1, 0, 1, 0);
        chk(par_diff() == 0, "R6", "parity differs under valid gaps", par_diff(), 0);
    endtask

    task automatic t_junk();
        run_cw(5, 0, 0, 1, 1, 0);
        chk(par_diff() == 0, "R3", "placeholder data leaked", par_diff(), 0);
    endtask

    task automatic t_zero();
        int nz = 0;
        run_cw(0, 0, 0, 0, 1, 1);
        for (int t = 0; t < NP; t++) if (cap[K+t] != 0) nz++;
        chk(nz == 0, "R9", "zero message parity nonzero", nz, 0);
    endtask

    task automatic t_impulse();
        int bad = 0;
        run_cw(0, 0, 0, 0, 1, 2);
        for (int t = 0; t < NP; t++) if (int'(cap[K+t]) != gpoly[NP-1-t]) bad++;
        chk(bad == 0, "R9", "impulse parity vs generator", bad, 0);
    endtask

    task automatic t_abort();
        send_partial(100, 1, 9);
        run_cw(5, 0, 0, 0, 1, 0);
        chk(par_diff() == 0, "R4", "parity after aborted codeword", par_diff(), 0);
    endtask

    task automatic t_mid_reset();
        send_partial(200, 1, 13);
        do_reset();
        run_cw(5, 0, 0, 0, 0, 0);
        chk(par_diff() == 0, "R7", "parity after mid-codeword reset", par_diff(), 0);
    endtask

    task automatic t_back_to_back();
        run_cw(21, 1, 1, 1, 1, 0);
        run_cw(22, 1, 1, 0, 1, 0);
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        for (int i = 0; i <= NP; i++) gpoly[i] = 0;
        gpoly[0] = 1;
        begin
            int root = 1;
            for (int i = 0; i < NP; i++) begin
                for (int j = i + 1; j >= 1; j--) gpoly[j] = gpoly[j-1] ^ gmul(gpoly[j], root);
                gpoly[0] = gmul(gpoly[0], root);
                root = gmul(root, 2);
            end
        end
        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
        in_data = '0; in_sof = 1'b0; in_eof = 1'b0;
        t_reset_state();
        t_reference();
        t_stall();
        t_gaps();
        t_junk();
        t_zero();
        t_impulse();
        t_abort();
        t_mid_reset();
        t_back_to_back();
        finish_up();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end
endmodule